// File: doc/BRIEF.md
# Trap Entry and Return Status Stack

This block performs the control-state bookkeeping for a software trap and for the matching return. It holds the processor status byte and a two-level save chain for both the program counter and the status byte. When a trap strobe arrives with a 4-bit trap number, the chain is pushed one level down. The address after the trapping instruction and the live status are saved. The live status is masked so that only the stack-mode bit survives. A redirect to the handler is issued at a fixed vector base plus four bytes per trap number.

When a return strobe arrives, the chain pops one level. The saved address is rounded down to a word boundary and issued as the redirect target. The live status comes back from the first backup, and the first backup is refilled from the second. Outside of traps and returns, the core can load the status byte through a plain write port. Every update lands in one clock edge, and every output comes straight from a register.

Top module: `trap_stack_unit`

## Requirements
- R1: After a synchronous reset, the status, both status backups, both PC backups and the redirect PC all read zero, and `redir_valid` is low.
- R2: On a trap, the second-level PC backup takes the old first-level PC backup, and the first-level PC backup takes `cur_pc` plus 4.
- R3: On a trap, the second-level status backup takes the old first-level status backup, and the first-level status backup takes the old live status.
- R4: On a trap, the live status becomes the old status ANDed with 0x80. Bit 7 (stack mode) is kept and bits 6..0 (interrupt enable, condition and the rest) are cleared.
- R5: On a trap, in the next cycle `redir_valid` is high for one cycle and `redir_pc` equals the vector base (default 0x40) plus 4 times the 4-bit unsigned `trap_num`.
- R6: On a return, in the next cycle `redir_valid` is high for one cycle and `redir_pc` equals the first-level PC backup with its two low bits cleared.
- R7: On a return, the live status takes the first-level status backup, and the first-level status backup takes the second-level one. The first-level PC backup takes the second-level one. Both second-level backups keep their values.
- R8: When trap and return are strobed in the same cycle, only the trap takes effect.
- R9: `stat_we` loads `stat_wdata` into the live status only in a cycle with neither trap nor return. In a trap or return cycle the write is ignored.
- R10: In a cycle with no strobe, `redir_valid` is low the next cycle, and the PC backups, status backups and `redir_pc` keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trap_req | input | 1 | Trap strobe |
| trap_num | input | 4 | Trap number sampled with the trap strobe |
| ret_req | input | 1 | Return strobe |
| cur_pc | input | 32 | Address of the trapping instruction |
| stat_we | input | 1 | Plain status write enable |
| stat_wdata | input | 8 | Plain status write data |
| redir_valid | output | 1 | One-cycle redirect pulse |
| redir_pc | output | 32 | Redirect target, held between pulses |
| stat_o | output | 8 | Live status byte |
| stat_bk1_o | output | 8 | First-level status backup |
| stat_bk2_o | output | 8 | Second-level status backup |
| pc_bk1_o | output | 32 | First-level PC backup |
| pc_bk2_o | output | 32 | Second-level PC backup |

## Verification
The trap path is driven with nested traps, up to three deep, and with status values that have bit 7 set and cleared. This separates a correct one-level shift from a chain that drops or duplicates a level, and tests the mask bit by bit. Returns are driven after traps at unaligned addresses, which exposes a missing round-down and a pop that runs in the wrong direction. Traps and returns are also driven on the same edge, and status writes are driven together with strobes and in idle cycles. These cases check the priority order between the three kinds of update and confirm that idle cycles hold all state.

// File: rtl/trap_stack_pkg.sv
package trap_stack_pkg;
  typedef enum logic [1:0] {
    STK_IDLE  = 2'd0,
    STK_TRAP  = 2'd1,
    STK_RET   = 2'd2,
    STK_WRITE = 2'd3
  } stk_op_e;

  // trap beats return beats a plain status write
  function automatic stk_op_e stk_pick(input logic trap, input logic ret,
                                       input logic wr);
    if (trap)     return STK_TRAP;
    else if (ret) return STK_RET;
    else if (wr)  return STK_WRITE;
    else          return STK_IDLE;
  endfunction
endpackage

// File: rtl/trap_op_sel.sv
module trap_op_sel
  import trap_stack_pkg::*;
(
  input  logic    trap_req,
  input  logic    ret_req,
  input  logic    stat_we,
  output stk_op_e op
);
  always_comb begin
    op = stk_pick(trap_req, ret_req, stat_we);
  end
endmodule

// File: rtl/trap_pc_chain.sv
module trap_pc_chain
  import trap_stack_pkg::*;
#(
  parameter int unsigned PC_W       = 32,
  parameter int unsigned NUM_W      = 4,
  parameter int unsigned ALIGN_BITS = 2,
  parameter int unsigned VEC_BASE   = 32'h40
) (
  input  logic             clk,
  input  logic             rst,
  input  stk_op_e          op,
  input  logic [PC_W-1:0]  cur_pc,
  input  logic [NUM_W-1:0] trap_num,
  output logic             redir_valid,
  output logic [PC_W-1:0]  redir_pc,
  output logic [PC_W-1:0]  pc_bk1,
  output logic [PC_W-1:0]  pc_bk2
);
  localparam logic [PC_W-1:0] STEP     = PC_W'(1) << ALIGN_BITS;
  localparam logic [PC_W-1:0] ALIGN_MK = ~(STEP - PC_W'(1));
  localparam logic [PC_W-1:0] BASE     = PC_W'(VEC_BASE);

  logic [PC_W-1:0] vec_pc;
  logic [PC_W-1:0] ret_pc;
  logic [PC_W-1:0] next_bk1;

  always_comb begin
    vec_pc   = BASE + (PC_W'(trap_num) << ALIGN_BITS);
    ret_pc   = pc_bk1 & ALIGN_MK;
    next_bk1 = cur_pc + STEP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      redir_valid <= 1'b0;
      redir_pc    <= '0;
      pc_bk1      <= '0;
      pc_bk2      <= '0;
    end else begin
      redir_valid <= 1'b0;
      unique case (op)
        STK_TRAP: begin
          pc_bk2      <= pc_bk1;
          pc_bk1      <= next_bk1;
          redir_pc    <= vec_pc;
          redir_valid <= 1'b1;
        end
        STK_RET: begin
          pc_bk1      <= pc_bk2;
          redir_pc    <= ret_pc;
          redir_valid <= 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/trap_stat_chain.sv
module trap_stat_chain
  import trap_stack_pkg::*;
#(
  parameter int unsigned       STAT_W    = 8,
  parameter logic [STAT_W-1:0] KEEP_MASK = 8'h80
) (
  input  logic              clk,
  input  logic              rst,
  input  stk_op_e           op,
  input  logic [STAT_W-1:0] wdata,
  output logic [STAT_W-1:0] stat,
  output logic [STAT_W-1:0] stat_bk1,
  output logic [STAT_W-1:0] stat_bk2
);
  logic [STAT_W-1:0] masked;

  for (genvar g = 0; g < STAT_W; g++) begin : g_mask
    if (KEEP_MASK[g]) begin : g_keep
      assign masked[g] = stat[g];
    end else begin : g_clr
      assign masked[g] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat     <= '0;
      stat_bk1 <= '0;
      stat_bk2 <= '0;
    end else begin
      unique case (op)
        STK_TRAP: begin
          stat_bk2 <= stat_bk1;
          stat_bk1 <= stat;
          stat     <= masked;
        end
        STK_RET: begin
          stat     <= stat_bk1;
          stat_bk1 <= stat_bk2;
        end
        STK_WRITE: stat <= wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/trap_stack_unit.sv
module trap_stack_unit
  import trap_stack_pkg::*;
#(
  parameter int unsigned       PC_W      = 32,
  parameter int unsigned       NUM_W     = 4,
  parameter int unsigned       STAT_W    = 8,
  parameter int unsigned       VEC_BASE  = 32'h40,
  parameter logic [STAT_W-1:0] KEEP_MASK = 8'h80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trap_req,
  input  logic [NUM_W-1:0]  trap_num,
  input  logic              ret_req,
  input  logic [PC_W-1:0]   cur_pc,
  input  logic              stat_we,
  input  logic [STAT_W-1:0] stat_wdata,
  output logic              redir_valid,
  output logic [PC_W-1:0]   redir_pc,
  output logic [STAT_W-1:0] stat_o,
  output logic [STAT_W-1:0] stat_bk1_o,
  output logic [STAT_W-1:0] stat_bk2_o,
  output logic [PC_W-1:0]   pc_bk1_o,
  output logic [PC_W-1:0]   pc_bk2_o
);
  stk_op_e op;

  trap_op_sel u_sel (
    .trap_req (trap_req),
    .ret_req  (ret_req),
    .stat_we  (stat_we),
    .op       (op)
  );

  trap_pc_chain #(
    .PC_W       (PC_W),
    .NUM_W      (NUM_W),
    .ALIGN_BITS (2),
    .VEC_BASE   (VEC_BASE)
  ) u_pc (
    .clk         (clk),
    .rst         (rst),
    .op          (op),
    .cur_pc      (cur_pc),
    .trap_num    (trap_num),
    .redir_valid (redir_valid),
    .redir_pc    (redir_pc),
    .pc_bk1      (pc_bk1_o),
    .pc_bk2      (pc_bk2_o)
  );

  trap_stat_chain #(
    .STAT_W    (STAT_W),
    .KEEP_MASK (KEEP_MASK)
  ) u_stat (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .wdata    (stat_wdata),
    .stat     (stat_o),
    .stat_bk1 (stat_bk1_o),
    .stat_bk2 (stat_bk2_o)
  );
endmodule

// File: rtl/trap_stack_checker.sv
module trap_stack_checker #(
  parameter int unsigned       PC_W      = 32,
  parameter int unsigned       NUM_W     = 4,
  parameter int unsigned       STAT_W    = 8,
  parameter int unsigned       VEC_BASE  = 32'h40,
  parameter logic [STAT_W-1:0] KEEP_MASK = 8'h80
) (
  input logic              clk,
  input logic              rst,
  input logic              trap_req,
  input logic [NUM_W-1:0]  trap_num,
  input logic              ret_req,
  input logic [PC_W-1:0]   cur_pc,
  input logic              stat_we,
  input logic [STAT_W-1:0] stat_wdata,
  input logic              redir_valid,
  input logic [PC_W-1:0]   redir_pc,
  input logic [STAT_W-1:0] stat_o,
  input logic [STAT_W-1:0] stat_bk1_o,
  input logic [STAT_W-1:0] stat_bk2_o,
  input logic [PC_W-1:0]   pc_bk1_o,
  input logic [PC_W-1:0]   pc_bk2_o
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  p_pc_push_r2: assert property (@(posedge clk) disable iff (rst)
    past_ok && trap_req |=> pc_bk2_o == $past(pc_bk1_o) &&
                            pc_bk1_o == $past(cur_pc) + PC_W'(4));

  p_stat_push_r3: assert property (@(posedge clk) disable iff (rst)
    past_ok && trap_req |=> stat_bk2_o == $past(stat_bk1_o) &&
                            stat_bk1_o == $past(stat_o));

  p_stat_mask_r4: assert property (@(posedge clk) disable iff (rst)
    past_ok && trap_req |=> stat_o == ($past(stat_o) & KEEP_MASK));

  p_vector_r5: assert property (@(posedge clk) disable iff (rst)
    past_ok && trap_req |=> redir_valid &&
      redir_pc == PC_W'(VEC_BASE) + (PC_W'($past(trap_num)) << 2));

  p_return_pc_r6: assert property (@(posedge clk) disable iff (rst)
    past_ok && ret_req && !trap_req |=> redir_valid &&
      redir_pc == ($past(pc_bk1_o) & ~PC_W'(3)));

  p_pop_r7: assert property (@(posedge clk) disable iff (rst)
    past_ok && ret_req && !trap_req |=> stat_o == $past(stat_bk1_o) &&
      stat_bk1_o == $past(stat_bk2_o) && $stable(stat_bk2_o) &&
      pc_bk1_o == $past(pc_bk2_o) && $stable(pc_bk2_o));

  p_write_r9: assert property (@(posedge clk) disable iff (rst)
    past_ok && stat_we && !trap_req && !ret_req |=> stat_o == $past(stat_wdata));

  p_idle_r10: assert property (@(posedge clk) disable iff (rst)
    past_ok && !trap_req && !ret_req |=> !redir_valid && $stable(redir_pc) &&
      $stable(pc_bk1_o) && $stable(pc_bk2_o) && $stable(stat_bk1_o) &&
      $stable(stat_bk2_o));
endmodule

bind trap_stack_unit trap_stack_checker #(
  .PC_W (PC_W), .NUM_W (NUM_W), .STAT_W (STAT_W),
  .VEC_BASE (VEC_BASE), .KEEP_MASK (KEEP_MASK)
) u_chk (.*);

// File: tb/trap_stack_unit_tb_top.sv
module trap_stack_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        trap_req, ret_req, stat_we;
  logic [3:0]  trap_num;
  logic [31:0] cur_pc;
  logic [7:0]  stat_wdata;
  logic        redir_valid;
  logic [31:0] redir_pc, pc_bk1_o, pc_bk2_o;
  logic [7:0]  stat_o, stat_bk1_o, stat_bk2_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // behavioural reference state
  logic        m_rv;
  logic [31:0] m_rpc, m_bpc, m_bbpc;
  logic [7:0]  m_st, m_bst, m_bbst;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_stack_unit dut_i (
    .clk(clk), .rst(rst), .trap_req(trap_req), .trap_num(trap_num),
    .ret_req(ret_req), .cur_pc(cur_pc), .stat_we(stat_we),
    .stat_wdata(stat_wdata), .redir_valid(redir_valid), .redir_pc(redir_pc),
    .stat_o(stat_o), .stat_bk1_o(stat_bk1_o), .stat_bk2_o(stat_bk2_o),
    .pc_bk1_o(pc_bk1_o), .pc_bk2_o(pc_bk2_o)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string t_pc, input string t_rd,
                             input string t_st, input string t_bk);
    check(t_rd, "redir_valid", 32'(redir_valid), 32'(m_rv));
    check(t_rd, "redir_pc",    redir_pc,          m_rpc);
    check(t_pc, "pc_bk1",      pc_bk1_o,          m_bpc);
    check(t_pc, "pc_bk2",      pc_bk2_o,          m_bbpc);
    check(t_st, "stat",        32'(stat_o),       32'(m_st));
    check(t_bk, "stat_bk1",    32'(stat_bk1_o),   32'(m_bst));
    check(t_bk, "stat_bk2",    32'(stat_bk2_o),   32'(m_bbst));
  endtask

  // one cycle: drive at negedge, clock, update model, compare at next negedge
  task automatic step(input logic tr, input logic [3:0] num, input logic rt,
                      input logic [31:0] pc, input logic we,
                      input logic [7:0] wd);
    string tp, tr_s, ts, tb;
    trap_req = tr; trap_num = num; ret_req = rt; cur_pc = pc;
    stat_we = we; stat_wdata = wd;
    @(posedge clk);
    if (tr) begin
      m_bbpc = m_bpc; m_bpc = pc + 32'd4;
      m_bbst = m_bst; m_bst = m_st; m_st = m_st & 8'h80;
      m_rv = 1'b1; m_rpc = 32'h40 + {26'd0, num, 2'b00};
      tp = "R2"; tr_s = "R5"; ts = "R4"; tb = "R3";
    end else if (rt) begin
      m_rv = 1'b1; m_rpc = m_bpc & ~32'd3;
      m_st = m_bst; m_bst = m_bbst; m_bpc = m_bbpc;
      tp = "R7"; tr_s = "R6"; ts = "R7"; tb = "R7";
    end else begin
      m_rv = 1'b0;
      if (we) m_st = wd;
      tp = "R10"; tr_s = "R10"; ts = "R9"; tb = "R10";
    end
    if (tr && rt) begin tp = "R8"; tr_s = "R8"; ts = "R8"; tb = "R8"; end
    if (we && (tr || rt)) ts = "R9";
    @(negedge clk);
    compare_all(tp, tr_s, ts, tb);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; trap_req = 0; ret_req = 0; stat_we = 0;
    trap_num = '0; cur_pc = '0; stat_wdata = '0;
    m_rv = 0; m_rpc = 0; m_bpc = 0; m_bbpc = 0; m_st = 0; m_bst = 0; m_bbst = 0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    compare_all("R1", "R1", "R1", "R1");

    step(0, 4'd0, 0, 32'h0,      1, 8'hC3);  // R9 plain write
    step(0, 4'd0, 0, 32'h0,      0, 8'h00);  // R10 idle
    step(1, 4'd3, 0, 32'h1002,   0, 8'h00);  // R2..R5 trap, unaligned pc
    step(0, 4'd0, 0, 32'h0,      1, 8'h5A);  // R9
    step(1, 4'd15, 0, 32'h2000,  1, 8'hFF);  // nested trap, write ignored
    step(0, 4'd0, 0, 32'h0,      1, 8'h7F);
    step(1, 4'd0, 0, 32'h3001,   0, 8'h00);  // third level, bit7 clear
    step(0, 4'd0, 0, 32'h0,      0, 8'h00);
    step(0, 4'd0, 1, 32'h0,      0, 8'h00);  // R6/R7 return
    step(0, 4'd0, 1, 32'h0,      1, 8'h11);  // return, write ignored
    step(0, 4'd0, 1, 32'h0,      0, 8'h00);
    step(0, 4'd0, 0, 32'h0,      1, 8'h80);
    step(1, 4'd9, 1, 32'h4446,   0, 8'h00);  // R8 both strobes
    step(0, 4'd0, 1, 32'h0,      0, 8'h00);
    step(1, 4'd1, 1, 32'h0FFF_FFFE, 1, 8'h22);
    step(0, 4'd0, 0, 32'h0,      0, 8'h00);
    for (int i = 0; i < 16; i++) begin
      step(1, 4'(i), 0, 32'h100 * i + 32'(i), (i % 3) == 0, 8'(i * 37));
      step(0, 4'd0, (i % 2) == 1, 32'h0, (i % 4) == 2, 8'(i * 11 + 5));
    end
    step(0, 4'd0, 0, 32'h0, 0, 8'h00);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule